// File: doc/BRIEF.md
# Two-Line Write-Through Cache

This block sits between a processor load/store port and a slower byte memory. It keeps two lines, and each line holds a block of two bytes. Any block may occupy either line, so there is no index field. A 5-bit byte address is split into a 4-bit tag in bits [4:1] and a word-select bit in bit [0].

Loads and stores that miss first fetch the whole block into a line, so stores also allocate. The line chosen is an empty one if one exists, otherwise the line that was used least recently. Stores update the cached byte and then send only that byte to memory. Memory therefore always matches the cache, and replacing a line never writes anything back.

The processor side uses valid/ready. A request is taken on a clock edge where `cpu_valid` and `cpu_ready` are both high. `cpu_ready` then stays low until the block has answered that request. The answer is a one-cycle `rsp_valid` pulse, and it cannot be back-pressured. The memory side uses req/ack for each byte. `mem_req` and its address, direction and data hold steady until the memory raises `mem_ack` for one cycle. Two counters record hits and misses.

Top module: `wt_cache`

## Requirements
- R1: While reset is asserted and right after it, no line is valid, both counters read 0, `cpu_ready` is high, and `mem_req` and `rsp_valid` are low.
- R2: Address bits [4:1] are the tag and bit [0] selects the byte within a block. A block may be placed in either line.
- R3: A load hit returns the cached byte with `rsp_hit`=1 and issues no memory access. `rsp_valid` is high in the second cycle after the accepting edge.
- R4: On a miss, the block makes exactly two memory reads before answering: first address {tag,0}, then {tag,1}. It then answers with `rsp_hit`=0.
- R5: A store that misses fills the line first and then writes the new byte into it, so a later load of that byte hits and returns the stored value.
- R6: Every store, whether it hits or misses, issues exactly one memory write with the store's own address and data.
- R7: Replacing a line issues no memory write, and a load never causes a memory write.
- R8: On a miss, an invalid line is filled before any valid one, lowest index first. When both lines are valid, the least recently used line is replaced. Every hit and every fill makes the line it touches the most recent.
- R9: `cpu_ready` is low from the accepting edge until the cycle after `rsp_valid`. Exactly one `rsp_valid` pulse follows each accepted request, and `rsp_valid` has no back-pressure.
- R10: In the cycle after each `rsp_valid`, exactly one counter has gone up by one: `hit_count` if the access hit, otherwise `miss_count`. At all other times neither counter changes.
- R11: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Block can take a request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Loaded byte (the stored byte for a store) |
| rsp_hit | output | 1 | 1 if the access hit on lookup |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory finished the current byte |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| hit_count | output | CNT_W | Accesses that hit |
| miss_count | output | CNT_W | Accesses that missed |

## Verification
The bench sends a sequence of accesses that fills both lines and then forces replacements. If the block evicted the most recent line instead of the oldest, the hit/miss pattern would change. If it did not reuse a line freed by reset, the pattern would also change.

Loads that come after stores check that memory was updated without any write-back. A design that left the store only in the cache would return old data after that line was replaced. The bench counts memory traffic for every access, so each miss must make two reads in ascending order and each store exactly one write. An extra write on eviction, or a missing write on a store miss, shows up as a wrong count.

A second reset in the middle of the run must make earlier cached blocks miss again.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FILL,
    ST_STORE,
    ST_DONE
  } wtc_state_e;
endpackage

// File: rtl/wtc_line_array.sv
module wtc_line_array #(
  parameter int LINES  = 2,
  parameter int WORDS  = 2,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 4,
  parameter int IDX_W  = 1,
  parameter int OFS_W  = 1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  fill_we,
  input  logic                                  fill_last,
  input  logic [IDX_W-1:0]                      fill_line,
  input  logic [OFS_W-1:0]                      fill_word,
  input  logic [DATA_W-1:0]                     fill_data,
  input  logic [TAG_W-1:0]                      fill_tag,
  input  logic                                  upd_we,
  input  logic [IDX_W-1:0]                      upd_line,
  input  logic [OFS_W-1:0]                      upd_word,
  input  logic [DATA_W-1:0]                     upd_data,
  output logic [LINES-1:0]                      valid_o,
  output logic [LINES-1:0][TAG_W-1:0]           tags_o,
  output logic [LINES-1:0][WORDS-1:0][DATA_W-1:0] data_o
);
  logic [LINES-1:0]                       valid_q;
  logic [LINES-1:0][TAG_W-1:0]            tags_q;
  logic [LINES-1:0][WORDS-1:0][DATA_W-1:0] data_q;

  // a line turns valid only once its last byte has arrived
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (fill_we && fill_last) valid_q[fill_line] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_we) begin
      data_q[fill_line][fill_word] <= fill_data;
      if (fill_last) tags_q[fill_line] <= fill_tag;
    end
    if (upd_we) data_q[upd_line][upd_word] <= upd_data;
  end

  assign valid_o = valid_q;
  assign tags_o  = tags_q;
  assign data_o  = data_q;
endmodule

// File: rtl/wtc_recency.sv
module wtc_recency #(
  parameter int LINES = 2,
  parameter int IDX_W = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         touch_en,
  input  logic [IDX_W-1:0]             touch_idx,
  output logic [LINES-1:0][IDX_W-1:0]  ages_o
);
  // age 0 = most recent, age LINES-1 = replacement candidate
  logic [LINES-1:0][IDX_W-1:0] ages_q;

  for (genvar g = 0; g < LINES; g++) begin : g_age
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ages_q[g] <= IDX_W'(g);
      else if (touch_en) begin
        if (IDX_W'(g) == touch_idx) ages_q[g] <= '0;
        else if (ages_q[g] < ages_q[touch_idx]) ages_q[g] <= ages_q[g] + 1'b1;
      end
    end
  end

  assign ages_o = ages_q;
endmodule

// File: rtl/wtc_match.sv
module wtc_match #(
  parameter int LINES = 2,
  parameter int TAG_W = 4,
  parameter int IDX_W = 1
) (
  input  logic [LINES-1:0]             valid_i,
  input  logic [LINES-1:0][TAG_W-1:0]  tags_i,
  input  logic [LINES-1:0][IDX_W-1:0]  ages_i,
  input  logic [TAG_W-1:0]             req_tag,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx,
  output logic [IDX_W-1:0]             victim_idx
);
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (valid_i[i] && tags_i[i] == req_tag) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (ages_i[i] == IDX_W'(LINES-1)) victim_idx = IDX_W'(i);
    // an empty line wins over the oldest one; lowest index last so it wins
    for (int i = LINES-1; i >= 0; i--)
      if (!valid_i[i]) victim_idx = IDX_W'(i);
  end
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int LINES  = 2,
  parameter int WORDS  = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_hit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int OFS_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int TAG_W = ADDR_W - OFS_W;
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  wtc_state_e          state_q;
  logic                req_we_q;
  logic [ADDR_W-1:0]   req_addr_q;
  logic [DATA_W-1:0]   req_wdata_q;
  logic [OFS_W-1:0]    fill_cnt_q;
  logic                missed_q;
  logic [IDX_W-1:0]    line_q;
  logic [DATA_W-1:0]   rdata_q;

  logic [TAG_W-1:0]    req_tag;
  logic [OFS_W-1:0]    req_ofs;
  logic                hit;
  logic [IDX_W-1:0]    hit_idx, victim_idx;
  logic                fill_we, fill_last, upd_we, touch_en;
  logic [LINES-1:0]                        valid_w;
  logic [LINES-1:0][TAG_W-1:0]             tags_w;
  logic [LINES-1:0][WORDS-1:0][DATA_W-1:0] data_w;
  logic [LINES-1:0][IDX_W-1:0]             ages_w;

  assign req_tag   = req_addr_q[ADDR_W-1:OFS_W];
  assign req_ofs   = req_addr_q[OFS_W-1:0];
  assign fill_we   = (state_q == ST_FILL) && mem_ack;
  assign fill_last = (fill_cnt_q == OFS_W'(WORDS-1));
  assign touch_en  = (state_q == ST_CHECK) && hit;
  assign upd_we    = touch_en && req_we_q;

  wtc_line_array #(
    .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W),
    .TAG_W(TAG_W), .IDX_W(IDX_W), .OFS_W(OFS_W)
  ) u_lines (
    .clk(clk), .rst_n(rst_n),
    .fill_we(fill_we), .fill_last(fill_last), .fill_line(line_q),
    .fill_word(fill_cnt_q), .fill_data(mem_rdata), .fill_tag(req_tag),
    .upd_we(upd_we), .upd_line(hit_idx), .upd_word(req_ofs), .upd_data(req_wdata_q),
    .valid_o(valid_w), .tags_o(tags_w), .data_o(data_w)
  );

  wtc_recency #(.LINES(LINES), .IDX_W(IDX_W)) u_recency (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(hit_idx), .ages_o(ages_w)
  );

  wtc_match #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
    .valid_i(valid_w), .tags_i(tags_w), .ages_i(ages_w), .req_tag(req_tag),
    .hit(hit), .hit_idx(hit_idx), .victim_idx(victim_idx)
  );

  // a filled line is looked up again, so the fill also refreshes recency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      fill_cnt_q  <= '0;
      missed_q    <= 1'b0;
      line_q      <= '0;
      rdata_q     <= '0;
      hit_count   <= '0;
      miss_count  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cpu_valid) begin
          req_we_q    <= cpu_we;
          req_addr_q  <= cpu_addr;
          req_wdata_q <= cpu_wdata;
          missed_q    <= 1'b0;
          state_q     <= ST_CHECK;
        end
        ST_CHECK: if (hit) begin
          rdata_q <= req_we_q ? req_wdata_q : data_w[hit_idx][req_ofs];
          state_q <= req_we_q ? ST_STORE : ST_DONE;
        end else begin
          missed_q   <= 1'b1;
          line_q     <= victim_idx;
          fill_cnt_q <= '0;
          state_q    <= ST_FILL;
        end
        ST_FILL: if (mem_ack) begin
          if (fill_last) state_q <= ST_CHECK;
          else fill_cnt_q <= fill_cnt_q + 1'b1;
        end
        ST_STORE: if (mem_ack) state_q <= ST_DONE;
        ST_DONE: begin
          if (missed_q) miss_count <= miss_count + 1'b1;
          else hit_count <= hit_count + 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_rdata = rdata_q;
  assign rsp_hit   = !missed_q;
  assign mem_req   = (state_q == ST_FILL) || (state_q == ST_STORE);
  assign mem_we    = (state_q == ST_STORE);
  assign mem_addr  = (state_q == ST_STORE) ? req_addr_q : {req_tag, fill_cnt_q};
  assign mem_wdata = req_wdata_q;
endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int WORDS  = 2,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              rsp_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  localparam int OFS_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic              seen_we;
  logic [ADDR_W-1:0] seen_addr;
  logic [DATA_W-1:0] seen_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_we <= 1'b0; seen_addr <= '0; seen_wdata <= '0;
    end else if (cpu_valid && cpu_ready) begin
      seen_we <= cpu_we; seen_addr <= cpu_addr; seen_wdata <= cpu_wdata;
    end
  end

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || rsp_valid) |-> !cpu_ready);

  a_r10_one_counter: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> ((hit_count != $past(hit_count)) != (miss_count != $past(miss_count))));

  a_r10_idle_counters: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |=> $stable(hit_count) && $stable(miss_count));

  a_r6_store_word: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr == seen_addr && mem_wdata == seen_wdata);

  a_r7_no_evict_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> seen_we);

  a_r4_fill_tag: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_addr[ADDR_W-1:OFS_W] == seen_addr[ADDR_W-1:OFS_W]);
endmodule

bind wt_cache wt_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .rsp_valid(rsp_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/wt_cache_test.sv
`timescale 1ns/1ps
module wt_cache_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [4:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic       cpu_ready, rsp_valid, rsp_hit;
  logic [7:0] rsp_rdata;
  logic       mem_req, mem_we, mem_ack = 1'b0;
  logic [4:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = '0;
  logic [15:0] hit_count, miss_count;

  int checks = 0, errors = 0;
  int mem_reads = 0, mem_writes = 0, rd_idx = 0;
  logic [4:0] rd_log [2];
  logic [7:0] mem_model [32];
  logic [7:0] gold [32];
  bit finished = 0;

  always #10 clk = ~clk;

  wt_cache uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  // {store, addr[4:0], data[7:0], expected hit}
  localparam logic [14:0] VEC [14] = '{
    {1'b0, 5'd1,  8'h00, 1'b0}, {1'b0, 5'd7,  8'h00, 1'b0},
    {1'b1, 5'd0,  8'hA5, 1'b1}, {1'b1, 5'd5,  8'h3C, 1'b0},
    {1'b0, 5'd10, 8'h00, 1'b0}, {1'b1, 5'd11, 8'h77, 1'b1},
    {1'b0, 5'd4,  8'h00, 1'b1}, {1'b0, 5'd0,  8'h00, 1'b0},
    {1'b0, 5'd11, 8'h00, 1'b0}, {1'b0, 5'd1,  8'h00, 1'b1},
    {1'b1, 5'd6,  8'h11, 1'b0}, {1'b0, 5'd7,  8'h00, 1'b1},
    {1'b0, 5'd6,  8'h00, 1'b1}, {1'b0, 5'd1,  8'h00, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // memory: one wait cycle, then a one-cycle ack
  initial begin
    int wait_cnt = 0;
    for (int a = 0; a < 32; a++) begin
      mem_model[a] = 8'((a * 13 + 5) & 255);
      gold[a] = mem_model[a];
    end
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_cnt == 1) begin
          wait_cnt = 0;
          mem_ack = 1'b1;
          if (mem_we) begin
            mem_model[mem_addr] = mem_wdata;
            mem_writes++;
          end else begin
            mem_rdata = mem_model[mem_addr];
            if (rd_idx < 2) rd_log[rd_idx] = mem_addr;
            rd_idx++;
            mem_reads++;
          end
        end else wait_cnt++;
      end
    end
  end

  task automatic access(input logic we, input logic [4:0] addr, input logic [7:0] wd,
                        input logic exp_hit, input bool_chk_lat);
    int rd0, wr0, cycles;
    bit busy_ok;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    rd0 = mem_reads; wr0 = mem_writes; rd_idx = 0;
    @(negedge clk);
    cpu_valid = 1'b0;
    cycles = 1; busy_ok = 1;
    while (!rsp_valid && cycles < 100) begin
      if (cpu_ready) busy_ok = 0;
      @(negedge clk);
      cycles++;
    end
    if (we) gold[addr] = wd;
    check(rsp_valid && busy_ok, "R9 ready low until response", int'(busy_ok), 1);
    check(rsp_hit == exp_hit, "R8/R2 hit pattern", int'(rsp_hit), int'(exp_hit));
    check(rsp_rdata == gold[addr], "R3/R5 returned byte", int'(rsp_rdata), int'(gold[addr]));
    check(mem_reads - rd0 == (exp_hit ? 0 : 2), "R4 fill read count", mem_reads - rd0, exp_hit ? 0 : 2);
    check(mem_writes - wr0 == (we ? 1 : 0), "R6/R7 write count", mem_writes - wr0, we ? 1 : 0);
    if (!exp_hit) begin
      check(rd_log[0] == {addr[4:1], 1'b0}, "R4 first fill address", int'(rd_log[0]), int'({addr[4:1], 1'b0}));
      check(rd_log[1] == {addr[4:1], 1'b1}, "R4 second fill address", int'(rd_log[1]), int'({addr[4:1], 1'b1}));
    end
    if (we) check(mem_model[addr] == wd, "R6 memory holds store", int'(mem_model[addr]), int'(wd));
    if (bool_chk_lat && exp_hit && !we) check(cycles == 2, "R3 hit latency", cycles, 2);
  endtask

  typedef bit bool_chk_lat;

  initial begin
    repeat (3) @(negedge clk);
    check(cpu_ready && !mem_req && !rsp_valid, "R1 reset outputs", int'(cpu_ready), 1);
    check(hit_count == 0 && miss_count == 0, "R1 reset counters", int'(hit_count + miss_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_ready && !mem_req, "R1 idle after reset", int'(cpu_ready), 1);

    for (int i = 0; i < 14; i++)
      access(VEC[i][14], VEC[i][13:9], VEC[i][8:1], VEC[i][0], 1'b1);

    @(negedge clk);
    check(hit_count == 7, "R10 hit counter", int'(hit_count), 7);
    check(miss_count == 7, "R10 miss counter", int'(miss_count), 7);

    // second reset: lines emptied, counters cleared
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(hit_count == 0 && miss_count == 0, "R1 counters cleared", int'(hit_count), 0);
    rst_n = 1'b1;
    access(1'b0, 5'd1, 8'h00, 1'b0, 1'b0);
    access(1'b0, 5'd0, 8'h00, 1'b1, 1'b1);
    @(negedge clk);
    check(miss_count == 1 && hit_count == 1, "R10 counts after reset", int'(miss_count), 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule